// File: doc/BRIEF.md
# Memory Protection Access Checker

This block decides whether a memory access may go ahead under a set of protection entries. Each entry supplies an inclusive lower and upper byte bound, a two-bit match mode (zero means the entry is switched off), a lock flag and three permission bits. A request is presented with a start pulse: the access start address, its size in bytes, the requested read/write/execute bits and a machine-mode flag are captured. The block then scans the entries one per clock, from index 0 upward, and stops at the first entry that decides.

An entry decides when it is active and it touches the access. If only one of the first byte and the last byte (start + size - 1) lies inside its bounds, the access is denied and flagged as partial. If both lie inside, the requested bits are compared with the granted bits. Machine mode is granted everything by an unlocked entry. When nothing decides, machine mode is allowed and every other mode is denied. When no entry is active at all, every access is allowed.

Top module: `prot_access_check`

## Requirements
- R1: After reset, `done`, `busy`, `allow` and `partial` are all 0.
- R2: When every entry has mode 0 (off), the request is allowed with `partial` = 0, and `done` rises one cycle after the start is taken.
- R3: `done` is a one-cycle pulse. It comes k+1 clock edges after the edge that takes `start` when entry k decides, and NUM_ENTRIES edges after it when no entry decides. `busy` is high from the taking edge until `done` rises.
- R4: If exactly one of the first and last byte lies within an active entry's inclusive bounds, and no lower entry has decided, the result is `allow` = 0 and `partial` = 1.
- R5: If both end bytes lie within an active entry, the access is allowed only when every requested bit is granted. Permission bits per entry and request bits are [0] read, [1] write, [2] execute.
- R6: In machine mode an unlocked matching entry grants read, write and execute. A locked entry grants only its permission bits, in every mode.
- R7: Entries are scanned in ascending index order, and the lowest-index deciding entry sets the result.
- R8: If at least one entry is active but none decides, the access is allowed in machine mode and denied otherwise, with `partial` = 0.
- R9: A size of 0 is treated as XLEN_BYTES (default 4) bytes.
- R10: Entries with mode 0 never decide, whatever their bounds, even if the access would straddle those bounds.
- R11: `allow` and `partial` keep their value from `done` until the next result. A `start` while `busy` is ignored, and the request in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Take a new request (ignored while busy) |
| acc_addr | input | ADDR_W | Access start byte address |
| acc_size | input | SIZE_W | Access size in bytes, 0 means XLEN_BYTES |
| acc_req | input | 3 | Requested bits: [0] read, [1] write, [2] execute |
| acc_mach | input | 1 | Access comes from machine mode |
| ent_lo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bounds, entry i at [i*ADDR_W +: ADDR_W] |
| ent_hi | input | NUM_ENTRIES*ADDR_W | Inclusive upper bounds, same packing |
| ent_mode | input | NUM_ENTRIES*2 | Match mode per entry, 0 = off |
| ent_lock | input | NUM_ENTRIES | Lock flag per entry |
| ent_perm | input | NUM_ENTRIES*3 | Permission bits per entry, [0] read, [1] write, [2] execute |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result strobe |
| allow | output | 1 | Access permitted |
| partial | output | 1 | Result came from a partial overlap |

## Verification
The hardest case to reach from the ports is an ordering conflict. A lower off entry, or a lower entry the access does not touch, must be passed over, and a higher entry must decide against a still higher entry that would give the opposite answer. The stimulus builds overlapping windows in entries 2 and 5, with an off entry 1 whose bounds the access straddles. The done latency then shows which entry decided. A second start is also fired in the middle of a full-length scan to show that the request in flight is not disturbed.

// File: rtl/prot_access_check.sv
module prot_access_check #(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 4,
  parameter int XLEN_BYTES  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [SIZE_W-1:0]             acc_size,
  input  logic [2:0]                    acc_req,
  input  logic                          acc_mach,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] ent_hi,
  input  logic [NUM_ENTRIES*2-1:0]      ent_mode,
  input  logic [NUM_ENTRIES-1:0]        ent_lock,
  input  logic [NUM_ENTRIES*3-1:0]      ent_perm,
  output logic                          busy,
  output logic                          done,
  output logic                          allow,
  output logic                          partial
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] q_first, q_last;
  logic [2:0]        q_req;
  logic              q_mach;

  logic [NUM_ENTRIES-1:0] active;
  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : g_act
      assign active[g] = |ent_mode[g*2 +: 2];
    end
  endgenerate

  wire [ADDR_W-1:0] eff_size = (acc_size == '0) ? ADDR_W'(XLEN_BYTES) : ADDR_W'(acc_size);
  wire [ADDR_W-1:0] last_byte = acc_addr + eff_size - ADDR_W'(1);

  wire [ADDR_W-1:0] cur_lo  = ent_lo[idx*ADDR_W +: ADDR_W];
  wire [ADDR_W-1:0] cur_hi  = ent_hi[idx*ADDR_W +: ADDR_W];
  wire [2:0]        cur_pm  = ent_perm[idx*3 +: 3];
  wire              cur_on  = active[idx];
  wire              cur_lk  = ent_lock[idx];

  wire first_in = (q_first >= cur_lo) && (q_first <= cur_hi);
  wire last_in  = (q_last  >= cur_lo) && (q_last  <= cur_hi);
  wire [2:0] granted = (q_mach && !cur_lk) ? 3'b111 : cur_pm;
  wire req_ok = (q_req & ~granted) == 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      allow   <= 1'b0;
      partial <= 1'b0;
      idx     <= '0;
      q_first <= '0;
      q_last  <= '0;
      q_req   <= '0;
      q_mach  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          idx     <= '0;
          q_first <= acc_addr;
          q_last  <= last_byte;
          q_req   <= acc_req;
          q_mach  <= acc_mach;
        end
      end else if (active == '0) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        allow   <= 1'b1;
        partial <= 1'b0;
      end else if (cur_on && (first_in ^ last_in)) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        allow   <= 1'b0;
        partial <= 1'b1;
      end else if (cur_on && first_in && last_in) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        allow   <= req_ok;
        partial <= 1'b0;
      end else if (idx == LAST_IDX) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        allow   <= q_mach;
        partial <= 1'b0;
      end else begin
        idx <= idx + IDX_W'(1);
      end
    end
  end
endmodule

module prot_access_check_sva #(
  parameter int NUM_ENTRIES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic allow,
  input logic partial
);
  localparam int CW = $clog2(NUM_ENTRIES + 1) + 1;
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + CW'(1);
    else busy_cnt <= '0;
  end

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  a_r3_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < CW'(NUM_ENTRIES));
  a_r4_partial_denies: assert property (@(posedge clk) disable iff (!rst_n)
    partial |-> !allow);
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(allow) && $stable(partial));
  a_r11_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind prot_access_check prot_access_check_sva #(.NUM_ENTRIES(NUM_ENTRIES)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .allow(allow), .partial(partial)
);

// File: tb/test_prot_access_check.sv
module test_prot_access_check;
  localparam int N  = 8;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0]    acc_size = '0;
  logic [2:0]    acc_req = '0;
  logic          acc_mach = 1'b0;
  logic [AW-1:0] lo [N];
  logic [AW-1:0] hi [N];
  logic [1:0]    md [N];
  logic [2:0]    pm [N];
  logic [N-1:0]  ent_lock;
  logic [N*AW-1:0] ent_lo, ent_hi;
  logic [N*2-1:0]  ent_mode;
  logic [N*3-1:0]  ent_perm;
  logic busy, done, allow, partial;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_lo[i*AW +: AW] = lo[i];
      ent_hi[i*AW +: AW] = hi[i];
      ent_mode[i*2 +: 2] = md[i];
      ent_perm[i*3 +: 3] = pm[i];
    end
  end

  prot_access_check i_prot_access_check (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_req(acc_req), .acc_mach(acc_mach),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_mode(ent_mode),
    .ent_lock(ent_lock), .ent_perm(ent_perm),
    .busy(busy), .done(done), .allow(allow), .partial(partial)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic request(input logic [AW-1:0] a, input logic [3:0] s, input logic [2:0] r,
                         input logic m, input string req, input int exp_allow,
                         input int exp_part, input int exp_lat, input bit poke_busy);
    int lat;
    @(negedge clk);
    acc_addr = a; acc_size = s; acc_req = r; acc_mach = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int c = 1; c <= N + 2; c++) begin
      if (poke_busy && c == 3) begin
        acc_addr = 32'h1000; acc_mach = 1'b1; acc_req = 3'b000; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done) begin lat = c; break; end
    end
    check({req, " latency"}, lat, exp_lat);
    check({req, " allow"}, int'(allow), exp_allow);
    check({req, " partial"}, int'(partial), exp_part);
    @(negedge clk);
    check({req, " done pulse R3"}, int'(done), 0);
    check({req, " held allow R11"}, int'(allow), exp_allow);
  endtask

  task automatic clear_entries();
    for (int i = 0; i < N; i++) begin
      lo[i] = '0; hi[i] = '0; md[i] = 2'b00; pm[i] = 3'b000;
    end
    ent_lock = '0;
  endtask

  task automatic t_reset();
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 allow", int'(allow), 0);
    check("R1 partial", int'(partial), 0);
  endtask

  task automatic t_all_off();
    clear_entries();
    lo[0] = 32'h1000; hi[0] = 32'h1fff;
    request(32'h1ffe, 4'd4, 3'b111, 1'b0, "R2 all off", 1, 0, 1, 1'b0);
  endtask

  task automatic t_perm();
    clear_entries();
    lo[0] = 32'h1000; hi[0] = 32'h1fff; md[0] = 2'b01; pm[0] = 3'b001;
    request(32'h1000, 4'd4, 3'b001, 1'b0, "R5 read ok", 1, 0, 1, 1'b0);
    request(32'h1000, 4'd4, 3'b010, 1'b0, "R5 write denied", 0, 0, 1, 1'b0);
    request(32'h1800, 4'd2, 3'b101, 1'b0, "R5 read+exec denied", 0, 0, 1, 1'b0);
    request(32'h1ffe, 4'd4, 3'b001, 1'b0, "R4 partial top", 0, 1, 1, 1'b0);
    request(32'h0ffe, 4'd4, 3'b001, 1'b1, "R4 partial bottom", 0, 1, 1, 1'b0);
    request(32'h1000, 4'd4, 3'b010, 1'b1, "R6 machine unlocked", 1, 0, 1, 1'b0);
    ent_lock[0] = 1'b1;
    request(32'h1000, 4'd4, 3'b010, 1'b1, "R6 machine locked", 0, 0, 1, 1'b0);
    request(32'h1000, 4'd4, 3'b001, 1'b1, "R6 machine locked read", 1, 0, 1, 1'b0);
  endtask

  task automatic t_order();
    clear_entries();
    lo[0] = 32'h1000; hi[0] = 32'h1fff; md[0] = 2'b01; pm[0] = 3'b001;
    lo[1] = 32'h3000; hi[1] = 32'h30ff; md[1] = 2'b00;
    lo[2] = 32'h3000; hi[2] = 32'h3fff; md[2] = 2'b11; pm[2] = 3'b011;
    lo[5] = 32'h3000; hi[5] = 32'h3fff; md[5] = 2'b01; pm[5] = 3'b000;
    request(32'h3100, 4'd4, 3'b010, 1'b0, "R7 lower entry wins", 1, 0, 3, 1'b0);
    request(32'h30fe, 4'd4, 3'b001, 1'b0, "R10 off entry skipped", 1, 0, 3, 1'b0);
    md[2] = 2'b00;
    request(32'h3100, 4'd4, 3'b001, 1'b0, "R7 falls to entry 5", 0, 0, 6, 1'b0);
  endtask

  task automatic t_nomatch();
    request(32'h9000, 4'd4, 3'b001, 1'b0, "R8 user no match", 0, 0, N, 1'b0);
    request(32'h9000, 4'd4, 3'b111, 1'b1, "R8 machine no match", 1, 0, N, 1'b0);
    request(32'h9000, 4'd4, 3'b001, 1'b0, "R11 start while busy", 0, 0, N, 1'b1);
  endtask

  task automatic t_size0();
    clear_entries();
    lo[0] = 32'h1000; hi[0] = 32'h1fff; md[0] = 2'b10; pm[0] = 3'b001;
    request(32'h1ffc, 4'd0, 3'b001, 1'b0, "R9 size0 fits", 1, 0, 1, 1'b0);
    request(32'h1ffd, 4'd0, 3'b001, 1'b0, "R9 size0 straddles", 0, 1, 1, 1'b0);
    request(32'h1ffd, 4'd1, 3'b001, 1'b0, "R9 size1 fits", 1, 0, 1, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 allow held idle", int'(allow), 1);
  endtask

  initial begin
    clear_entries();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_off();
    t_perm();
    t_order();
    t_nomatch();
    t_size0();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule